// File: doc/BRIEF.md
# Predicated Floating-Point Compare Unit

This block compares two IEEE-754 operands, either single precision (32-bit) or double precision (64-bit), and turns their relation into one condition-flag bit chosen by a small predicate code. The relation is first reduced to exactly one of four outcomes: less, equal, greater or unordered. A predicate then decides whether that outcome raises the flag. The compare is quiet, so a quiet NaN only yields "unordered". A signaling NaN also records a sticky invalid-operation bit.

Each compare strobe also merges the flag into a 32-bit status/control register. The flag goes to bit 29. Bits 28, 30 and 31 are cleared. The low field is kept, except that the invalid bit can only be set. Software reads this register at all times and can overwrite it through a direct write port. A direct write wins over a compare that lands in the same cycle.

A two-state machine times the result. `ST_IDLE` moves to `ST_DONE` on a strobe (transition *accept*). `ST_DONE` stays in `ST_DONE` on another strobe (*chain*) and returns to `ST_IDLE` without one (*retire*). `done_o` is high exactly while the machine is in `ST_DONE`.

Top module: `fp_cmp_unit`

## Requirements
- R1: Whenever either operand is a NaN, the relation is unordered. Predicate code 1 raises the flag only for an unordered relation.
- R2: Predicate codes are: 0 never; 1 unordered; 2 equal; 3 unordered or equal; 4 less; 5 unordered or less; 6 less or equal; 7 anything but greater. Bit 0 of the code admits unordered, bit 1 admits equal and bit 2 admits less. Greater never raises the flag.
- R3: Only bits 2:0 of the 4-bit `cond_i` are decoded. Bit 3 has no effect on the flag or on the status register.
- R4: Positive zero and negative zero compare equal.
- R5: Non-NaN, non-zero operands are ordered by sign first. When both operands are negative, the magnitude order is reversed (for example, -2.0 is less than -1.0).
- R6: When `cmp_double_i` is 0, only bits 31:0 of each operand are used (sign 31, exponent 30:23, fraction 22:0). Bits 63:32 are ignored.
- R7: When `cmp_double_i` is 1, the full 64-bit operands are compared (sign 63, exponent 62:52, fraction 51:0) with the same predicates.
- R8: After a compare without a direct write, status bit 29 equals the new flag, bits 31, 30 and 28 are 0, and bits 27:1 keep their previous values.
- R9: A NaN whose fraction MSB is 0 is signaling and sets status bit 0. Bit 0 then stays set through later compares. A quiet NaN (fraction MSB 1) leaves bit 0 unchanged.
- R10: `flag_o` and `status_o` change on the clock edge that samples `cmp_valid_i`. `done_o` is high in the cycle after each strobe and low after a cycle without one. `flag_o` holds its value between strobes.
- R11: When `sw_wr_en_i` is high, the status register takes `sw_wr_data_i` on the next edge, even if a compare is strobed in the same cycle. That compare still updates `flag_o`.
- R12: After reset, `status_o` is 0 and `flag_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid_i | input | 1 | Compare strobe |
| cmp_double_i | input | 1 | 1 = double precision, 0 = single precision |
| cond_i | input | 4 | Predicate code (bits 2:0 used) |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| sw_wr_en_i | input | 1 | Direct status write enable |
| sw_wr_data_i | input | 32 | Direct status write value |
| status_o | output | 32 | Status/control register |
| flag_o | output | 1 | Condition flag |
| done_o | output | 1 | Result-valid pulse |

## Verification
A wrong relation or predicate decode shows up on `flag_o`, and on status bit 29, one cycle after the strobe. A corrupted merge shows up at the same edge as a stray high bit in 31:28 or a changed low field. A state machine stuck in `ST_DONE` leaves `done_o` high in the first idle cycle. A lost sticky invalid bit is visible on `status_o` bit 0 at the next compare. The scoreboard compares every result at its done pulse, so a fault surfaces within one or two cycles of the offending strobe.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    // Four-way relation between two operands
    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    // Result timing machine
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } fsm_e;

    // Per-operand classification
    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
        logic sign;
    } cls_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]   val_i,
    output cls_t                    cls_o,
    output logic [EXP_W+FRAC_W-1:0] mag_o
);
    localparam int MAG_W = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              frac_nz;

    always_comb begin
        exp_f          = val_i[MAG_W-1:FRAC_W];
        frac_f         = val_i[FRAC_W-1:0];
        exp_ones       = &exp_f;
        frac_nz        = |frac_f;
        cls_o.sign     = val_i[MAG_W];
        cls_o.is_nan   = exp_ones & frac_nz;
        // A NaN with a clear top fraction bit is signaling
        cls_o.is_snan  = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
        cls_o.is_zero  = ~(|val_i[MAG_W-1:0]);
        mag_o          = val_i[MAG_W-1:0];
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] a_i,
    input  logic [EXP_W+FRAC_W:0] b_i,
    output rel_e                  rel_o,
    output logic                  snan_o
);
    localparam int MAG_W = EXP_W + FRAC_W;

    cls_t             cls_a;
    cls_t             cls_b;
    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             a_bigger;

    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
        .val_i (a_i),
        .cls_o (cls_a),
        .mag_o (mag_a)
    );

    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
        .val_i (b_i),
        .cls_o (cls_b),
        .mag_o (mag_b)
    );

    always_comb begin
        snan_o   = cls_a.is_snan | cls_b.is_snan;
        a_bigger = mag_a > mag_b;
        if (cls_a.is_nan || cls_b.is_nan) begin
            rel_o = REL_UN;
        end else if (cls_a.is_zero && cls_b.is_zero) begin
            rel_o = REL_EQ;
        end else if (cls_a.sign != cls_b.sign) begin
            rel_o = cls_a.sign ? REL_LT : REL_GT;
        end else if (mag_a == mag_b) begin
            rel_o = REL_EQ;
        end else begin
            // Both negative: larger magnitude is the smaller value
            rel_o = (a_bigger ^ cls_a.sign) ? REL_GT : REL_LT;
        end
    end
endmodule

// File: rtl/fpcmp_predicate.sv
module fpcmp_predicate
    import fpcmp_pkg::*;
(
    input  logic [2:0] code_i,
    input  rel_e       rel_i,
    output logic       hit_o
);
    always_comb begin
        unique case (code_i)
            3'd0:    hit_o = 1'b0;
            3'd1:    hit_o = (rel_i == REL_UN);
            3'd2:    hit_o = (rel_i == REL_EQ);
            3'd3:    hit_o = (rel_i == REL_EQ) || (rel_i == REL_UN);
            3'd4:    hit_o = (rel_i == REL_LT);
            3'd5:    hit_o = (rel_i == REL_LT) || (rel_i == REL_UN);
            3'd6:    hit_o = (rel_i == REL_LT) || (rel_i == REL_EQ);
            3'd7:    hit_o = (rel_i != REL_GT);
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
    import fpcmp_pkg::*;
#(
    parameter int SP_EXP_W    = 8,
    parameter int SP_FRAC_W   = 23,
    parameter int DP_EXP_W    = 11,
    parameter int DP_FRAC_W   = 52,
    parameter int COND_W      = 4,
    parameter int STATUS_W    = 32,
    parameter int FLAG_POS    = 29,
    parameter int INVALID_POS = 0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmp_valid_i,
    input  logic                           cmp_double_i,
    input  logic [COND_W-1:0]              cond_i,
    input  logic [DP_EXP_W+DP_FRAC_W:0]    op_a_i,
    input  logic [DP_EXP_W+DP_FRAC_W:0]    op_b_i,
    input  logic                           sw_wr_en_i,
    input  logic [STATUS_W-1:0]            sw_wr_data_i,
    output logic [STATUS_W-1:0]            status_o,
    output logic                           flag_o,
    output logic                           done_o
);
    localparam int N_PREC    = 2;
    localparam int CLR_LOW   = FLAG_POS - 1;

    rel_e               rel_arr  [N_PREC];
    logic [N_PREC-1:0]  snan_arr;
    rel_e               rel_sel;
    logic               snan_sel;
    logic               hit;
    logic [STATUS_W-1:0] status_q;
    logic [STATUS_W-1:0] merged;
    logic               flag_q;
    fsm_e               state_q;
    fsm_e               state_d;

    // One order path per precision; index 0 single, index 1 double
    for (genvar g = 0; g < N_PREC; g++) begin : gen_prec
        localparam int EW = (g == 0) ? SP_EXP_W  : DP_EXP_W;
        localparam int FW = (g == 0) ? SP_FRAC_W : DP_FRAC_W;
        localparam int W  = 1 + EW + FW;
        fpcmp_order #(.EXP_W(EW), .FRAC_W(FW)) u_order (
            .a_i    (op_a_i[W-1:0]),
            .b_i    (op_b_i[W-1:0]),
            .rel_o  (rel_arr[g]),
            .snan_o (snan_arr[g])
        );
    end

    always_comb begin
        rel_sel  = cmp_double_i ? rel_arr[1]  : rel_arr[0];
        snan_sel = cmp_double_i ? snan_arr[1] : snan_arr[0];
    end

    fpcmp_predicate u_pred (
        .code_i (cond_i[2:0]),
        .rel_i  (rel_sel),
        .hit_o  (hit)
    );

    // Status merge: flag into FLAG_POS, upper bits cleared, low kept
    always_comb begin
        merged = status_q;
        for (int i = CLR_LOW; i < STATUS_W; i++) begin
            merged[i] = 1'b0;
        end
        merged[FLAG_POS]    = hit;
        merged[INVALID_POS] = status_q[INVALID_POS] | snan_sel;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmp_valid_i) state_d = ST_DONE;
            ST_DONE: state_d = cmp_valid_i ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_IDLE: done_o = 1'b0;
            ST_DONE: done_o = 1'b1;
            default: done_o = 1'b0;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (cmp_valid_i) begin
                flag_q <= hit;
            end
            if (sw_wr_en_i) begin
                status_q <= sw_wr_data_i;
            end else if (cmp_valid_i) begin
                status_q <= merged;
            end
        end
    end

    assign status_o = status_q;
    assign flag_o   = flag_q;
endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmp_valid_i,
    input logic [3:0]  cond_i,
    input logic        sw_wr_en_i,
    input logic [31:0] sw_wr_data_i,
    input logic [31:0] status_o,
    input logic        flag_o,
    input logic        done_o
);
    assert_merge_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid_i && !sw_wr_en_i) |=> (status_o[31:28] == {3'b001, 1'b0} ? flag_o : (status_o[31:28] == 4'b0000 && !flag_o)));

    assert_keep_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid_i && !sw_wr_en_i) |=> (status_o[27:1] == $past(status_o[27:1])));

    assert_sw_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en_i |=> (status_o == $past(sw_wr_data_i)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid_i |=> done_o);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid_i |=> !done_o);

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid_i |=> $stable(flag_o));

    assert_never_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid_i && cond_i[2:0] == 3'd0) |=> !flag_o);

    assert_sticky_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en_i && status_o[0]) |=> status_o[0]);
endmodule

bind fp_cmp_unit fpcmp_checker u_fpcmp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_valid_i  (cmp_valid_i),
    .cond_i       (cond_i),
    .sw_wr_en_i   (sw_wr_en_i),
    .sw_wr_data_i (sw_wr_data_i),
    .status_o     (status_o),
    .flag_o       (flag_o),
    .done_o       (done_o)
);

// File: tb/fp_cmp_unit_bench.sv
module fp_cmp_unit_bench;

    typedef struct {
        logic        flag;
        logic [31:0] status;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid_i = 1'b0;
    logic        cmp_double_i = 1'b0;
    logic [3:0]  cond_i = '0;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic        sw_wr_en_i = 1'b0;
    logic [31:0] sw_wr_data_i = '0;
    logic [31:0] status_o;
    logic        flag_o;
    logic        done_o;

    int          n_checks = 0;
    int          n_errors = 0;
    item_t       sb_q[$];
    logic [31:0] model_status = '0;
    logic        model_flag = 1'b0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fp_cmp_unit u_fp_cmp_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_valid_i  (cmp_valid_i),
        .cmp_double_i (cmp_double_i),
        .cond_i       (cond_i),
        .op_a_i       (op_a_i),
        .op_b_i       (op_b_i),
        .sw_wr_en_i   (sw_wr_en_i),
        .sw_wr_data_i (sw_wr_data_i),
        .status_o     (status_o),
        .flag_o       (flag_o),
        .done_o       (done_o)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Independent model: 0 less, 1 equal, 2 greater, 3 unordered
    function automatic int rel_model(input logic [63:0] a, input logic [63:0] b, input bit dbl);
        longint ka, kb;
        bit na, nb;
        if (dbl) begin
            na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
            nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
            ka = a[63] ? -longint'(a[62:0]) : longint'(a[62:0]);
            kb = b[63] ? -longint'(b[62:0]) : longint'(b[62:0]);
        end else begin
            na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
            nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
            ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
            kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
        end
        if (na || nb) return 3;
        if (ka < kb) return 0;
        if (ka == kb) return 1;
        return 2;
    endfunction

    function automatic bit snan_model(input logic [63:0] v, input bit dbl);
        if (dbl) return (v[62:52] == 11'h7FF) && (v[51:0] != 0) && !v[51];
        return (v[30:23] == 8'hFF) && (v[22:0] != 0) && !v[22];
    endfunction

    // Driver: applies one strobe and pushes the expected result
    task automatic drive(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                         input logic [3:0] code, input bit wr, input logic [31:0] wdata,
                         input string tag);
        int    r;
        bit    f;
        item_t it;
        r = rel_model(a, b, dbl);
        case (r)
            3: f = code[0];
            1: f = code[1];
            0: f = code[2];
            default: f = 1'b0;
        endcase
        model_flag = f;
        if (wr) begin
            model_status = wdata;
        end else begin
            model_status[31:28] = {2'b00, f, 1'b0};
            if (snan_model(a, dbl) || snan_model(b, dbl)) model_status[0] = 1'b1;
        end
        it.flag = f;
        it.status = model_status;
        it.tag = tag;
        sb_q.push_back(it);
        cmp_valid_i  = 1'b1;
        cmp_double_i = dbl;
        cond_i       = code;
        op_a_i       = a;
        op_b_i       = b;
        sw_wr_en_i   = wr;
        sw_wr_data_i = wdata;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        cmp_valid_i = 1'b0;
        sw_wr_en_i  = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sw_write(input logic [31:0] d);
        sw_wr_en_i   = 1'b1;
        sw_wr_data_i = d;
        model_status = d;
        @(negedge clk);
        sw_wr_en_i = 1'b0;
        check(status_o, d, "R11 direct write");
    endtask

    // Monitor: pops and compares at every done pulse
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            item_t it;
            if (sb_q.size() == 0) begin
                check(1, 0, "R10 unexpected done");
            end else begin
                it = sb_q.pop_front();
                check(flag_o, it.flag, {it.tag, " flag"});
                check(status_o, it.status, {it.tag, " status"});
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    localparam logic [63:0] S_P1  = 64'h3F800000;
    localparam logic [63:0] S_P2  = 64'h40000000;
    localparam logic [63:0] S_M1  = 64'hBF800000;
    localparam logic [63:0] S_M2  = 64'hC0000000;
    localparam logic [63:0] S_PZ  = 64'h00000000;
    localparam logic [63:0] S_MZ  = 64'h80000000;
    localparam logic [63:0] S_QN  = 64'h7FC00000;
    localparam logic [63:0] S_SN  = 64'h7F800001;
    localparam logic [63:0] S_INF = 64'h7F800000;
    localparam logic [63:0] D_P1  = 64'h3FF0000000000000;
    localparam logic [63:0] D_P2  = 64'h4000000000000000;
    localparam logic [63:0] D_M3  = 64'hC008000000000000;
    localparam logic [63:0] D_QN  = 64'h7FF8000000000000;
    localparam logic [63:0] D_SN  = 64'h7FF0000000000001;

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(status_o, 32'h0, "R12 status");
        check(flag_o, 1'b0, "R12 flag");
        check(done_o, 1'b0, "R12 done");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 all eight codes over the four relations (single)
        for (int c = 0; c < 8; c++) begin
            drive(S_P1, S_P2, 1'b0, 4'(c), 1'b0, 32'h0, "R2 less");
            drive(S_P2, S_P2, 1'b0, 4'(c), 1'b0, 32'h0, "R2 equal");
            drive(S_P2, S_P1, 1'b0, 4'(c), 1'b0, 32'h0, "R2 greater");
            drive(S_QN, S_P1, 1'b0, 4'(c), 1'b0, 32'h0, "R1 unordered");
        end
        idle(2);
        check(done_o, 1'b0, "R10 done low when idle");

        // R8 low field preserved, top bits cleared
        sw_write(32'hF5A5_A5A4);
        drive(S_P1, S_P1, 1'b0, 4'd2, 1'b0, 32'h0, "R8 merge set");
        drive(S_P2, S_P1, 1'b0, 4'd2, 1'b0, 32'h0, "R8 merge clear");
        idle(3);
        check(flag_o, 1'b0, "R10 flag held");

        // R3 bit 3 of the code ignored
        drive(S_P2, S_P1, 1'b0, 4'b1000, 1'b0, 32'h0, "R3 code 8");
        drive(S_P1, S_P2, 1'b0, 4'b1100, 1'b0, 32'h0, "R3 code 12");
        // R4 signed zeros
        drive(S_PZ, S_MZ, 1'b0, 4'd2, 1'b0, 32'h0, "R4 zeros equal");
        drive(S_MZ, S_PZ, 1'b0, 4'd4, 1'b0, 32'h0, "R4 not less");
        // R5 negative ordering
        drive(S_M2, S_M1, 1'b0, 4'd4, 1'b0, 32'h0, "R5 -2 < -1");
        drive(S_M1, S_M2, 1'b0, 4'd4, 1'b0, 32'h0, "R5 -1 not < -2");
        drive(S_M1, S_P1, 1'b0, 4'd4, 1'b0, 32'h0, "R5 sign order");
        drive(S_INF, S_P2, 1'b0, 4'd6, 1'b0, 32'h0, "R5 inf greater");
        // R6 upper bits ignored in single mode
        drive(64'hFFFF_FFFF_3F80_0000, 64'h0000_0001_3F80_0000, 1'b0, 4'd2, 1'b0, 32'h0, "R6 upper ignored");
        drive(64'h7FF8_0000_3F80_0000, S_P2, 1'b0, 4'd1, 1'b0, 32'h0, "R6 upper NaN ignored");
        // R7 double precision
        drive(D_P1, D_P2, 1'b1, 4'd4, 1'b0, 32'h0, "R7 double less");
        drive(D_M3, D_P1, 1'b1, 4'd6, 1'b0, 32'h0, "R7 double neg");
        drive(D_P2, D_P2, 1'b1, 4'd3, 1'b0, 32'h0, "R7 double equal");
        drive(D_QN, D_P1, 1'b1, 4'd5, 1'b0, 32'h0, "R7 double unordered");
        drive(D_P2, D_P1, 1'b1, 4'd7, 1'b0, 32'h0, "R7 double greater");
        idle(1);

        // R9 quiet NaN leaves invalid clear, signaling sets it sticky
        sw_write(32'h0000_0010);
        drive(S_QN, S_QN, 1'b0, 4'd1, 1'b0, 32'h0, "R9 quiet nan");
        drive(S_P1, S_SN, 1'b0, 4'd1, 1'b0, 32'h0, "R9 signaling nan");
        drive(S_P1, S_P1, 1'b0, 4'd2, 1'b0, 32'h0, "R9 sticky");
        drive(D_SN, D_P1, 1'b1, 4'd7, 1'b0, 32'h0, "R9 double snan");
        idle(2);

        // R11 write beats a simultaneous compare; flag still updates
        drive(S_P1, S_P1, 1'b0, 4'd2, 1'b1, 32'h1234_5678, "R11 write priority");
        drive(S_P2, S_P1, 1'b0, 4'd4, 1'b0, 32'h0, "R11 after write");
        idle(3);
        sw_write(32'hDEAD_BEEF);
        check(flag_o, 1'b0, "R11 flag untouched by write");

        idle(2);
        check(sb_q.size(), 0, "R10 all results seen");
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule